// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Transaction Sequencer

This block is a bus master for a shared bus whose lines carry the address in one cycle and data in later cycles. A requester hands it one operation at a time: an operation code, a start address, a write word, a bit mask and a beat count. The sequencer then runs the whole operation on the bus. It drives the address with an address-valid strobe, then runs one or more data beats under separate read and write strobes. Each beat lasts until the target acknowledges it.

Besides plain single reads and writes, the sequencer runs four compound operations, each behind a single address phase. A read-modify-write reads a word and writes back a masked merge of it. A write-then-verify writes a word, then reads the same location back and compares the two. A block read and a block write each move several consecutive words. The master never re-issues the address inside an operation. The target keeps its own location pointer. That pointer moves to the next address after a beat only when the following beat of the same operation has the same direction. When the direction changes, the target stays on the address it last used.

The shared lines are modelled as three signals: an output value, an output enable and an input value. The tri-state pad itself sits outside the block.

Top module: `mux_bus_seq`

## Requirements
- R1: The first cycle after a request is accepted is the address phase. `bus_ale`=1 and `bus_ad_oe`=1 for exactly that one cycle, `bus_ad_o` carries `req_addr`, and `bus_rd` and `bus_wr` are both 0.
- R2: A read beat holds `bus_rd`=1 with `bus_ad_oe`=0 until a cycle with `bus_ack`=1. The word on `bus_ad_i` in that cycle appears on `rsp_rdata`, with `rsp_rvalid`=1, in the following cycle only.
- R3: A write beat holds `bus_wr`=1 and `bus_ad_oe`=1, with the word to be written held steady on `bus_ad_o`, until a cycle with `bus_ack`=1.
- R4: A read-modify-write (op code 2) has one address phase and one read beat. The write beat starts in the very next cycle and writes `(old & ~req_mask) | (req_wdata & req_mask)`. `rsp_rdata` returns the old word.
- R5: A write-then-verify (op code 3) runs a write beat of `req_wdata`, then one cycle with `bus_ad_oe`=0 and no strobe, then a read beat. In the done cycle, `rsp_mismatch` is 1 exactly when the word read back differs from the word written. `rsp_mismatch` is 0 for every other op code.
- R6: A block read (op 4) or block write (op 5) has one address phase followed by `req_beats`+1 back-to-back beats of one direction. A block read returns every beat through `rsp_rvalid`/`rsp_rdata`. A block write drives `req_wdata` on every beat. The beats reach consecutive target locations starting at `req_addr`.
- R7: Op code 0 is a single read and op code 1 is a single write. Op codes 6 and 7 are never accepted: no bus activity follows, and `req_ready` stays 1.
- R8: `req_ready` is 1 only while the sequencer is idle, and no strobe or output enable is active while it is. A request is accepted on a cycle with `req_valid`=1, `req_ready`=1 and a known op code. A request made while the sequencer is busy waits.
- R9: `rsp_done` is 1 for exactly one cycle, the cycle after the last beat is acknowledged. `req_ready` is already 1 in that cycle, so a new request can be accepted there.
- R10: Synchronous reset, even in the middle of an operation, leaves the sequencer idle. After reset `req_ready`=1, and `bus_ad_oe`, `bus_ale`, `bus_rd`, `bus_wr` and `rsp_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 3 | Operation code |
| req_addr | input | W | Start address |
| req_wdata | input | W | Write word, or merge value for read-modify-write |
| req_mask | input | W | Merge mask for read-modify-write |
| req_beats | input | BEAT_W | Block beats minus one |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rvalid | output | 1 | Read word valid on rsp_rdata |
| rsp_rdata | output | W | Read word |
| rsp_mismatch | output | 1 | Read-back differed from the written word |
| bus_ad_o | output | W | Value driven onto the shared lines |
| bus_ad_oe | output | 1 | Master drives the shared lines |
| bus_ad_i | input | W | Value seen on the shared lines |
| bus_ale | output | 1 | Address valid strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ack | input | 1 | Target acknowledge for the current beat |

## Verification
Two things can happen in the same cycle: the done pulse of one operation and the acceptance of the next request. The bench provokes this by raising a second request while the first is still on the bus and holding it until it is taken. The reference queue then expects the second address phase in the cycle right after `rsp_done`, with no idle gap. The same queue checks that the last read word of the first operation is still returned in the done cycle while the new operation has already started.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_WRITE  = 3'd1,
        OP_RMW    = 3'd2,
        OP_RAW    = 3'd3,
        OP_BLK_RD = 3'd4,
        OP_BLK_WR = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ADDR,
        SQ_RBEAT,
        SQ_WBEAT,
        SQ_TURN
    } seq_e;

    typedef struct packed {
        logic drive;
        logic ale;
        logic rd;
        logic wr;
    } busctl_t;

    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic logic op_is_block(input op_e o);
        return (o == OP_BLK_RD) || (o == OP_BLK_WR);
    endfunction

    function automatic logic op_reads_first(input op_e o);
        return (o == OP_READ) || (o == OP_RMW) || (o == OP_BLK_RD);
    endfunction

    function automatic logic rd_is_final(input op_e o, input logic last);
        return (o == OP_READ) || (o == OP_RAW) || ((o == OP_BLK_RD) && last);
    endfunction

    function automatic logic wr_is_final(input op_e o, input logic last);
        return (o == OP_WRITE) || (o == OP_RMW) || ((o == OP_BLK_WR) && last);
    endfunction

    function automatic busctl_t ctl_of(input seq_e s);
        busctl_t c;
        c = '0;
        case (s)
            SQ_ADDR:  begin c.drive = 1'b1; c.ale = 1'b1; end
            SQ_RBEAT: c.rd = 1'b1;
            SQ_WBEAT: begin c.drive = 1'b1; c.wr = 1'b1; end
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mbs_req_hold.sv
module mbs_req_hold
    import mbs_pkg::*;
#(
    parameter int W      = 16,
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        req_op,
    input  logic [W-1:0]      req_addr,
    input  logic [W-1:0]      req_wdata,
    input  logic [W-1:0]      req_mask,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic              beat_ack,
    output op_e               op_q,
    output logic [W-1:0]      addr_q,
    output logic [W-1:0]      value_q,
    output logic [W-1:0]      mask_q,
    output logic              last_beat
);
    logic [BEAT_W-1:0] left_q;
    op_e               op_in;

    assign op_in     = op_e'(req_op);
    assign last_beat = (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_READ;
            addr_q  <= '0;
            value_q <= '0;
            mask_q  <= '0;
            left_q  <= '0;
        end else if (start) begin
            op_q    <= op_in;
            addr_q  <= req_addr;
            value_q <= req_wdata;
            mask_q  <= req_mask;
            left_q  <= op_is_block(op_in) ? req_beats : '0;
        end else if (beat_ack && (left_q != '0)) begin
            left_q  <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/mbs_datapath.sv
module mbs_datapath
    import mbs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] req_wdata,
    input  op_e          op_q,
    input  logic [W-1:0] value_q,
    input  logic [W-1:0] mask_q,
    input  logic         rd_ack,
    input  logic [W-1:0] bus_ad_i,
    output logic [W-1:0] wword_q,
    output logic [W-1:0] rdata_q,
    output logic         rvalid_q,
    output logic         mismatch_q
);
    logic [W-1:0] merged;

    assign merged = (bus_ad_i & ~mask_q) | (value_q & mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            wword_q    <= '0;
            rdata_q    <= '0;
            rvalid_q   <= 1'b0;
            mismatch_q <= 1'b0;
        end else begin
            rvalid_q <= rd_ack;
            if (rd_ack) begin
                rdata_q <= bus_ad_i;
            end
            if (start) begin
                wword_q    <= req_wdata;
                mismatch_q <= 1'b0;
            end else if (rd_ack && (op_q == OP_RMW)) begin
                wword_q <= merged;
            end else if (rd_ack && (op_q == OP_RAW)) begin
                mismatch_q <= (bus_ad_i != wword_q);
            end
        end
    end
endmodule

// File: rtl/mbs_seq_fsm.sv
module mbs_seq_fsm
    import mbs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic bus_ack,
    input  op_e  op_q,
    input  logic last_beat,
    output seq_e state_q,
    output logic rd_ack,
    output logic wr_ack,
    output logic fin_q
);
    seq_e nxt;
    logic fin;

    assign rd_ack = (state_q == SQ_RBEAT) && bus_ack;
    assign wr_ack = (state_q == SQ_WBEAT) && bus_ack;

    always_comb begin
        nxt = state_q;
        fin = 1'b0;
        case (state_q)
            SQ_IDLE: if (start) nxt = SQ_ADDR;
            SQ_ADDR: nxt = op_reads_first(op_q) ? SQ_RBEAT : SQ_WBEAT;
            SQ_RBEAT: begin
                if (bus_ack) begin
                    if (rd_is_final(op_q, last_beat)) begin
                        nxt = SQ_IDLE;
                        fin = 1'b1;
                    end else if (op_q == OP_RMW) begin
                        nxt = SQ_WBEAT;
                    end
                end
            end
            SQ_WBEAT: begin
                if (bus_ack) begin
                    if (wr_is_final(op_q, last_beat)) begin
                        nxt = SQ_IDLE;
                        fin = 1'b1;
                    end else if (op_q == OP_RAW) begin
                        nxt = SQ_TURN;
                    end
                end
            end
            SQ_TURN: nxt = SQ_RBEAT;
            default: nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            fin_q   <= 1'b0;
        end else begin
            state_q <= nxt;
            fin_q   <= fin;
        end
    end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int W      = 16,
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [W-1:0]      req_addr,
    input  logic [W-1:0]      req_wdata,
    input  logic [W-1:0]      req_mask,
    input  logic [BEAT_W-1:0] req_beats,
    output logic              rsp_done,
    output logic              rsp_rvalid,
    output logic [W-1:0]      rsp_rdata,
    output logic              rsp_mismatch,
    output logic [W-1:0]      bus_ad_o,
    output logic              bus_ad_oe,
    input  logic [W-1:0]      bus_ad_i,
    output logic              bus_ale,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic              bus_ack
);
    seq_e         state_q;
    busctl_t      ctl;
    op_e          op_q;
    logic [W-1:0] addr_q, value_q, mask_q, wword_q;
    logic         last_beat, rd_ack, wr_ack, start;

    assign req_ready = (state_q == SQ_IDLE);
    assign start     = req_valid && req_ready && op_known(req_op);

    mbs_req_hold #(.W(W), .BEAT_W(BEAT_W)) hold_i (
        .clk(clk), .rst(rst), .start(start),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .req_beats(req_beats),
        .beat_ack(rd_ack || wr_ack),
        .op_q(op_q), .addr_q(addr_q), .value_q(value_q), .mask_q(mask_q),
        .last_beat(last_beat)
    );

    mbs_seq_fsm fsm_i (
        .clk(clk), .rst(rst), .start(start), .bus_ack(bus_ack),
        .op_q(op_q), .last_beat(last_beat),
        .state_q(state_q), .rd_ack(rd_ack), .wr_ack(wr_ack), .fin_q(rsp_done)
    );

    mbs_datapath #(.W(W)) dp_i (
        .clk(clk), .rst(rst), .start(start), .req_wdata(req_wdata),
        .op_q(op_q), .value_q(value_q), .mask_q(mask_q),
        .rd_ack(rd_ack), .bus_ad_i(bus_ad_i),
        .wword_q(wword_q), .rdata_q(rsp_rdata), .rvalid_q(rsp_rvalid),
        .mismatch_q(rsp_mismatch)
    );

    assign ctl       = ctl_of(state_q);
    assign bus_ale   = ctl.ale;
    assign bus_rd    = ctl.rd;
    assign bus_wr    = ctl.wr;
    assign bus_ad_oe = ctl.drive;
    assign bus_ad_o  = ctl.ale ? addr_q : (ctl.drive ? wword_q : '0);
endmodule

// File: rtl/mbs_chk.sv
module mbs_chk #(
    parameter int W      = 16,
    parameter int BEAT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_op,
    input logic              rsp_done,
    input logic [W-1:0]      bus_ad_o,
    input logic              bus_ad_oe,
    input logic              bus_ale,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_ack
);
    // R10
    reset_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> req_ready && !bus_ad_oe && !bus_ale && !bus_rd && !bus_wr && !rsp_done);

    // R1
    ale_single_chk: assert property (@(posedge clk) disable iff (rst)
        bus_ale |=> !bus_ale);

    // R1
    ale_drive_chk: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> bus_ad_oe && !bus_rd && !bus_wr);

    // R2
    rd_release_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> !bus_ad_oe && !bus_wr);

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd && !bus_ack |=> bus_rd);

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr && !bus_ack |=> bus_wr && bus_ad_oe && $stable(bus_ad_o));

    // R5
    turn_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_ack |=> !bus_rd);

    // R7
    accept_known_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && (req_op <= 3'd5) |=> bus_ale);

    // R7
    reject_unknown_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && (req_op > 3'd5) |=> req_ready && !bus_ale);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_ad_oe && !bus_rd && !bus_wr);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R9
    done_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> req_ready);
endmodule

bind mux_bus_seq mbs_chk #(.W(W), .BEAT_W(BEAT_W)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .rsp_done(rsp_done), .bus_ad_o(bus_ad_o),
    .bus_ad_oe(bus_ad_oe), .bus_ale(bus_ale), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_ack(bus_ack)
);

// File: tb/mux_bus_seq_tb_top.sv
module mux_bus_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int BEAT_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [2:0]        req_op = 3'd0;
    logic [W-1:0]      req_addr = '0, req_wdata = '0, req_mask = '0;
    logic [BEAT_W-1:0] req_beats = '0;
    logic              rsp_done, rsp_rvalid, rsp_mismatch;
    logic [W-1:0]      rsp_rdata, bus_ad_o;
    logic              bus_ad_oe, bus_ale, bus_rd, bus_wr;
    logic [W-1:0]      bus_ad_i = '0;
    logic              bus_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_seq #(.W(W), .BEAT_W(BEAT_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .req_beats(req_beats),
        .rsp_done(rsp_done), .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata),
        .rsp_mismatch(rsp_mismatch), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
        .bus_ad_i(bus_ad_i), .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_ack(bus_ack)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- expected cycle queue ----------------
    typedef struct {
        bit ale, oe, rd, wr, done, rvalid, chk_ad, chk_rd, chk_mm, mm;
        logic [W-1:0] ad, rdata;
    } exp_t;

    exp_t         expq[$];
    int           tgt_waits[$];
    logic [W-1:0] ref_mem [256];
    logic [W-1:0] tgt_mem [256];
    bit           pend_rv = 0;
    logic [W-1:0] pend_val = '0;
    bit           tgt_corrupt = 0;

    function automatic exp_t blank();
        exp_t e;
        e = '{default: 0};
        return e;
    endfunction

    function automatic void push(exp_t e);
        if (pend_rv) begin
            e.rvalid = 1; e.chk_rd = 1; e.rdata = pend_val;
            pend_rv = 0;
        end
        expq.push_back(e);
    endfunction

    function automatic void rbeat(input logic [W-1:0] v, input int w);
        for (int i = 0; i <= w; i++) begin
            exp_t e = blank();
            e.rd = 1;
            push(e);
        end
        tgt_waits.push_back(w);
        pend_rv = 1; pend_val = v;
    endfunction

    function automatic void wbeat(input logic [W-1:0] v, input int w);
        for (int i = 0; i <= w; i++) begin
            exp_t e = blank();
            e.wr = 1; e.oe = 1; e.ad = v; e.chk_ad = 1;
            push(e);
        end
        tgt_waits.push_back(w);
    endfunction

    function automatic void build(input logic [2:0] op, input logic [W-1:0] addr,
                                  input logic [W-1:0] wd, input logic [W-1:0] mk,
                                  input int beats, input int w0, input int w1);
        exp_t e;
        logic [7:0] a;
        logic [W-1:0] old, nw;
        bit mm;
        a  = addr[7:0];
        mm = 0;
        e  = blank();
        e.ale = 1; e.oe = 1; e.ad = addr; e.chk_ad = 1;
        push(e);
        case (op)
            3'd0: rbeat(ref_mem[a], w0);
            3'd1: begin wbeat(wd, w0); ref_mem[a] = wd; end
            3'd2: begin
                old = ref_mem[a];
                rbeat(old, w0);
                nw = (old & ~mk) | (wd & mk);
                wbeat(nw, w1);
                ref_mem[a] = nw;
            end
            3'd3: begin
                wbeat(wd, w0);
                ref_mem[a] = wd;
                push(blank());
                rbeat(tgt_corrupt ? (wd ^ 16'h0010) : wd, w1);
                mm = tgt_corrupt;
            end
            3'd4: for (int k = 0; k <= beats; k++)
                      rbeat(ref_mem[8'(a + k)], (k % 2) ? w1 : w0);
            default: for (int k = 0; k <= beats; k++) begin
                      wbeat(wd, (k % 2) ? w1 : w0);
                      ref_mem[8'(a + k)] = wd;
                  end
        endcase
        e = blank();
        e.done = 1; e.chk_mm = 1; e.mm = mm;
        push(e);
    endfunction

    // ---------------- target model ----------------
    logic [7:0] taddr = '0;
    int  tcnt = 0;
    int  lastdir = 2;
    bit  newbeat = 0;

    always @(negedge clk) begin
        if (rst) begin
            bus_ack = 0; tcnt = 0; newbeat = 0; lastdir = 2;
        end else begin
            if (bus_ale) begin
                taddr = bus_ad_o[7:0]; newbeat = 1; lastdir = 2; tcnt = 0;
            end
            if (bus_rd || bus_wr) begin
                int dir;
                int wneed;
                dir = bus_wr ? 1 : 0;
                if (newbeat) begin
                    if (dir == lastdir) taddr = taddr + 8'd1;
                    newbeat = 0; tcnt = 0;
                end
                wneed = (tgt_waits.size() > 0) ? tgt_waits[0] : 0;
                if (tcnt >= wneed) begin
                    bus_ack = 1;
                    if (dir == 0) bus_ad_i = tgt_mem[taddr] ^ (tgt_corrupt ? 16'h0010 : 16'h0000);
                    else tgt_mem[taddr] = bus_ad_o;
                    lastdir = dir; newbeat = 1;
                    if (tgt_waits.size() > 0) void'(tgt_waits.pop_front());
                end else begin
                    bus_ack = 0; tcnt++; bus_ad_i = 16'hDEAD;
                end
            end else begin
                bus_ack = 0;
            end
        end
    end

    // ---------------- monitor, every cycle ----------------
    always @(negedge clk) begin
        if (!rst) begin
            exp_t e;
            if (expq.size() > 0) e = expq.pop_front();
            else e = blank();
            check(bus_ale == e.ale, "R1 ale", W'(bus_ale), W'(e.ale));
            check(bus_ad_oe == e.oe, "R2/R3 ad_oe", W'(bus_ad_oe), W'(e.oe));
            check(bus_rd == e.rd, "R2 rd strobe", W'(bus_rd), W'(e.rd));
            check(bus_wr == e.wr, "R3 wr strobe", W'(bus_wr), W'(e.wr));
            check(rsp_done == e.done, "R9 done", W'(rsp_done), W'(e.done));
            check(rsp_rvalid == e.rvalid, "R2 rvalid", W'(rsp_rvalid), W'(e.rvalid));
            if (e.chk_ad) check(bus_ad_o == e.ad, "R1/R3/R4 ad_o", bus_ad_o, e.ad);
            if (e.chk_rd) check(rsp_rdata == e.rdata, "R2/R6 rdata", rsp_rdata, e.rdata);
            if (e.chk_mm) check(rsp_mismatch == e.mm, "R5 mismatch", W'(rsp_mismatch), W'(e.mm));
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input logic [2:0] op, input logic [W-1:0] addr,
                         input logic [W-1:0] wd, input logic [W-1:0] mk,
                         input int beats, input int w0, input int w1);
        build(op, addr, wd, mk, beats, w0, w1);
        req_op = op; req_addr = addr; req_wdata = wd; req_mask = mk;
        req_beats = BEAT_W'(beats); req_valid = 1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic settle();
        while (expq.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        #1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            ref_mem[i] = W'(i * 16'h0101) ^ 16'h5A00;
            tgt_mem[i] = ref_mem[i];
        end
        repeat (3) @(negedge clk);
        // R10 reset state
        check(req_ready == 1, "R10 ready in reset", W'(req_ready), 1);
        check(!bus_ad_oe && !bus_ale && !bus_rd && !bus_wr, "R10 bus released",
              W'({bus_ad_oe, bus_ale, bus_rd, bus_wr}), 0);
        #1 rst = 0;
        @(negedge clk); #1;

        issue(3'd0, 16'h0010, 0, 0, 0, 0, 0);            // R7 single read, no waits
        settle();
        issue(3'd1, 16'h0011, 16'hBEEF, 0, 0, 2, 0);     // R3 single write with waits
        settle();
        issue(3'd0, 16'h0011, 0, 0, 0, 1, 0);            // R2 read back
        settle();
        issue(3'd2, 16'h0020, 16'h1234, 16'h00FF, 0, 1, 2); // R4
        settle();
        issue(3'd3, 16'h0030, 16'hA5A5, 0, 0, 0, 1);     // R5 clean
        settle();
        tgt_corrupt = 1;
        issue(3'd3, 16'h0031, 16'h3C3C, 0, 0, 1, 0);     // R5 corrupted read-back
        settle();
        tgt_corrupt = 0;
        issue(3'd4, 16'h0040, 0, 0, 3, 0, 2);            // R6 block read
        settle();
        issue(3'd5, 16'h0050, 16'h7777, 0, 2, 1, 0);     // R6 block write
        settle();
        issue(3'd4, 16'h0050, 0, 0, 3, 0, 0);            // R6 read back, incl. untouched word
        settle();
        issue(3'd4, 16'h0060, 0, 0, 0, 2, 0);            // R6 single-beat block
        settle();

        // R9 back-to-back: second request waits and is taken in the done cycle
        issue(3'd1, 16'h0070, 16'h0F0F, 0, 0, 1, 0);
        issue(3'd0, 16'h0070, 0, 0, 0, 0, 0);
        issue(3'd2, 16'h0070, 16'hFFFF, 16'hF000, 0, 0, 0);
        settle();

        // R7 unknown op codes ignored
        req_op = 3'd6; req_valid = 1;
        repeat (2) @(negedge clk);
        #1 check(req_ready == 1, "R7 op 6 ignored", W'(req_ready), 1);
        req_op = 3'd7;
        repeat (2) @(negedge clk);
        #1 check(req_ready == 1 && !bus_ale, "R7 op 7 ignored", W'(req_ready), 1);
        req_valid = 0;
        settle();

        // R10 reset in the middle of a read with a long wait
        issue(3'd0, 16'h0012, 0, 0, 0, 8, 0);
        repeat (3) @(negedge clk);
        #1 rst = 1;
        expq.delete(); tgt_waits.delete(); pend_rv = 0;
        repeat (2) @(negedge clk);
        #1 check(req_ready == 1 && !bus_rd && !bus_ad_oe, "R10 mid-op reset",
                 W'({req_ready, bus_rd, bus_ad_oe}), 3'b100);
        rst = 0;
        @(negedge clk); #1;
        check(!rsp_done && !bus_rd && !bus_wr, "R10 idle after reset",
              W'({rsp_done, bus_rd, bus_wr}), 0);
        issue(3'd0, 16'h0011, 0, 0, 0, 0, 1);            // R8 normal after reset
        settle();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule